// File: doc/BRIEF.md
# Programmable-Priority Peripheral Interrupt Controller

This block gathers level-sensitive interrupt requests from up to eight on-chip peripheral sources and tells the CPU core which one to take. Each source has a 4-bit priority. The block registers two results for the core: the highest active priority level, and the index of the source that holds it. Software sets the priorities and the per-source masks through a small synchronous register bus, with an address, a write strobe, write data and combinational read data.

A source competes for the core only when three things hold: it is requesting, its mask bit is clear, and its priority is nonzero. A priority of zero therefore mutes a source on its own, without touching the mask. The raw request register is different: it always shows what the sources are asking for, whatever the masks and priorities are. Software can use it to see requests that are being blocked.

The parameter `SRC_PRESENT` selects which of the eight source slots are implemented. With the default value, sources 6 and 7 are reserved. A reserved slot has no priority storage and no mask bit, and its request input is not seen.

Top module: `periph_irq_ctrl`

## Requirements
- R1: Register word 0 is the priority register. Source i owns bits [4i+3:4i], a value of 4'hF is the highest level (15), and the register reads back exactly what was last written for implemented sources.
- R2: Priority fields of reserved sources (those not set in `SRC_PRESENT`; by default 6 and 7) always read 0, and writes to them are ignored.
- R3: Register word 1 is the raw request register. Bit i reads `irq_req[i]` for each implemented source, whatever the mask and priority settings are. All other bits read 0, and writes to this word are ignored.
- R4: Register word 2 is the mask register. Writing 1 to bit i masks source i, writing 0 leaves that bit unchanged, and a read returns the mask bits (1 = masked). Reserved sources read 0.
- R5: Register word 3 is the mask-clear register. Writing 1 to bit i unmasks source i, writing 0 has no effect, and a read always returns 0.
- R6: `irq_level` is the highest priority among sources that are requesting, unmasked and have a nonzero priority. It is 0 when no such source exists, so a source with priority 0 never wins.
- R7: When two or more eligible sources share the highest level, `irq_src` reports the one with the lowest index.
- R8: `irq_level` and `irq_src` are registered. A change on `irq_req` shows at the outputs after one rising edge. A register write takes effect at the edge that captures it, and the outputs follow at the next edge. `irq_src` is 0 whenever `irq_level` is 0.
- R9: Reset clears every priority field to 0, masks every implemented source (the mask reads 0x3F by default), and drives `irq_level` and `irq_src` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 2 | Register word select |
| reg_we | input | 1 | Write strobe, captured at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | input | 8 | Level-sensitive request per source |
| irq_level | output | 4 | Winning priority level, 0 when none |
| irq_src | output | 3 | Index of the winning source |

## Verification
Read data is combinational, so the bench reads a register a short delay after it sets the address, all within one low clock phase. A change on `irq_req` is due at the outputs one rising edge later, so the bench drives requests on a falling edge and checks them at the next falling edge. A register write lands at one edge and reaches `irq_level` at the following edge. The bench therefore checks just after the write edge that the old level is still present, and checks one cycle later that the new level has arrived. In the vector table, each row settles for two full cycles before it is compared.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    SEL_PRIO   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_UNMASK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [NUM_SRC-1:0] SRC_PRESENT = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [REG_ADDR_W-1:0]     reg_addr,
  input  logic                      reg_we,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NUM_SRC-1:0]        irq_req,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]        mask_o,
  output logic [NUM_SRC-1:0]        raw_o
);
  localparam int unsigned PRIO_BITS = NUM_SRC * PRIO_W;

  logic prio_wr, mset_wr, mclr_wr;

  always_comb begin
    prio_wr = reg_we && (reg_addr == SEL_PRIO);
    mset_wr = reg_we && (reg_addr == SEL_MASK);
    mclr_wr = reg_we && (reg_addr == SEL_UNMASK);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (SRC_PRESENT[i]) begin : g_impl
      logic [PRIO_W-1:0] prio_q, prio_d;
      logic              mask_q, mask_d, mask_en;

      always_comb begin
        prio_d  = reg_wdata[i*PRIO_W +: PRIO_W];
        mask_en = (mset_wr || mclr_wr) && reg_wdata[i];
        mask_d  = mset_wr;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prio_q <= '0;
          mask_q <= 1'b1;
        end else begin
          if (prio_wr) prio_q <= prio_d;
          if (mask_en) mask_q <= mask_d;
        end
      end

      assign prio_o[i*PRIO_W +: PRIO_W] = prio_q;
      assign mask_o[i] = mask_q;
      assign raw_o[i]  = irq_req[i];
    end else begin : g_rsvd
      assign prio_o[i*PRIO_W +: PRIO_W] = '0;
      assign mask_o[i] = 1'b0;
      assign raw_o[i]  = 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      SEL_PRIO:   reg_rdata[PRIO_BITS-1:0] = prio_o;
      SEL_RAW:    reg_rdata[NUM_SRC-1:0]   = raw_o;
      SEL_MASK:   reg_rdata[NUM_SRC-1:0]   = mask_o;
      default:    reg_rdata = '0;
    endcase
  end

  // R4: after a write to the mask word, every written 1 is masked
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == SEL_MASK) |=>
      ((mask_o & $past(reg_wdata[NUM_SRC-1:0]) & SRC_PRESENT) ==
       ($past(reg_wdata[NUM_SRC-1:0]) & SRC_PRESENT)));

  // R5: after a write to the mask-clear word, every written 1 is unmasked
  a_r5_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == SEL_UNMASK) |=>
      ((mask_o & $past(reg_wdata[NUM_SRC-1:0])) == '0));

  // R2: reserved slots never expose a mask or a request
  a_r2_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_o | raw_o) & ~SRC_PRESENT) == '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [NUM_SRC-1:0]        mask_i,
  input  logic [NUM_SRC-1:0]        raw_i,
  output logic [PRIO_W-1:0]         level_o,
  output logic [SRC_W-1:0]          src_o
);
  logic [NUM_SRC-1:0] elig;
  logic [PRIO_W-1:0]  best_lvl;
  logic [SRC_W-1:0]   best_src;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = raw_i[i] && !mask_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0);
    end
  end

  // Walk from the top index down; ">=" lets lower indices take ties.
  always_comb begin
    best_lvl = '0;
    best_src = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (prio_i[i*PRIO_W +: PRIO_W] >= best_lvl)) begin
        best_lvl = prio_i[i*PRIO_W +: PRIO_W];
        best_src = SRC_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= '0;
      src_o   <= '0;
    end else begin
      level_o <= best_lvl;
      src_o   <= best_src;
    end
  end

  // R6: no request in the previous cycle means no level now
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_i) == '0) |-> (level_o == '0));

  // R6: a nonzero level belongs to a source that was requesting and unmasked
  a_r6_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != '0) |->
      ((($past(raw_i & ~mask_i) >> src_o) & {{(NUM_SRC-1){1'b0}}, 1'b1}) != '0));

  // R8: idle level reports source 0
  a_r8_idle_src: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == '0) |-> (src_o == '0));
endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter logic [NUM_SRC-1:0] SRC_PRESENT = 8'h3F,
  localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_we,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_SRC-1:0]    irq_req,
  output logic [PRIO_W-1:0]     irq_level,
  output logic [SRC_W-1:0]      irq_src
);
  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]        mask;
  logic [NUM_SRC-1:0]        raw;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .SRC_PRESENT(SRC_PRESENT)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .prio_o(prio), .mask_o(mask), .raw_o(raw)
  );

  irq_arbiter #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_int_n),
    .prio_i(prio), .mask_i(mask), .raw_i(raw),
    .level_o(irq_level), .src_o(irq_src)
  );

  // R9: while held in reset the outputs stay idle
  a_r9_reset_idle: assert property (@(posedge clk)
    (!rst_int_n && !$past(rst_int_n)) |-> (irq_level == '0 && irq_src == '0));
endmodule

// File: tb/periph_irq_ctrl_tb.sv
`timescale 1ns/1ps
module periph_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_req;
  logic [3:0]  irq_level;
  logic [2:0]  irq_src;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  periph_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_level(irq_level), .irq_src(irq_src)
  );

  // {prio[31:0], mask[7:0], req[7:0], level[3:0], src[2:0]}
  localparam logic [54:0] VEC [10] = '{
    {32'h0000_0321, 8'h00, 8'h07, 4'd3,  3'd2},
    {32'h0000_0321, 8'h04, 8'h07, 4'd2,  3'd1},
    {32'h0055_5500, 8'h00, 8'h3C, 4'd5,  3'd2},
    {32'h0055_5500, 8'h00, 8'h30, 4'd5,  3'd4},
    {32'h0000_00F0, 8'h00, 8'h01, 4'd0,  3'd0},
    {32'hFF00_0001, 8'h00, 8'hFF, 4'd1,  3'd0},
    {32'h00A0_0000, 8'h20, 8'h20, 4'd0,  3'd0},
    {32'h00A9_8765, 8'h00, 8'h3F, 4'd10, 3'd5},
    {32'h00A9_8765, 8'h20, 8'h3F, 4'd9,  3'd4},
    {32'h00A9_8765, 8'h00, 8'h00, 4'd0,  3'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; irq_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    check("R9 level", 32'(irq_level), 32'd0);
    check("R9 src", 32'(irq_src), 32'd0);
    rd(2'd0, r); check("R9 prio", r, 32'h0);
    rd(2'd2, r); check("R9 mask", r, 32'h3F);

    // Masked requests still visible in the raw word
    irq_req = 8'h05;
    wr(2'd0, 32'h0000_0707);
    @(negedge clk);
    check("R9 masked level", 32'(irq_level), 32'd0);
    rd(2'd1, r); check("R3 raw under mask", r, 32'h05);
    rd(2'd0, r); check("R1 prio readback", r, 32'h0000_0707);

    // Mask-clear: 0 is no-op, 1 unmasks, reads as 0
    wr(2'd3, 32'h0);
    rd(2'd2, r); check("R5 zero write", r, 32'h3F);
    wr(2'd3, 32'h04);
    check("R8 write not yet seen", 32'(irq_level), 32'd0);
    @(negedge clk);
    check("R8 level after write", 32'(irq_level), 32'd7);
    check("R8 src after write", 32'(irq_src), 32'd2);
    rd(2'd2, r); check("R5 unmask", r, 32'h3B);
    rd(2'd3, r); check("R5 read zero", r, 32'h0);

    // Mask set: 0 is no-op, 1 masks
    wr(2'd2, 32'h0);
    rd(2'd2, r); check("R4 zero write", r, 32'h3B);
    wr(2'd2, 32'h04);
    rd(2'd2, r); check("R4 set", r, 32'h3F);
    @(negedge clk);
    check("R4 masked level", 32'(irq_level), 32'd0);

    // Raw word ignores writes
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); check("R3 write ignored", r, 32'h05);

    // Tie and one-edge request timing
    wr(2'd3, 32'hFF);
    @(negedge clk);
    check("R7 tie level", 32'(irq_level), 32'd7);
    check("R7 tie src", 32'(irq_src), 32'd0);
    irq_req = 8'h04;
    @(negedge clk);
    check("R8 req one edge src", 32'(irq_src), 32'd2);
    irq_req = 8'h00;
    @(negedge clk);
    check("R8 idle level", 32'(irq_level), 32'd0);
    check("R8 idle src", 32'(irq_src), 32'd0);

    // Vector table
    for (int k = 0; k < 10; k++) begin
      wr(2'd0, VEC[k][54:23]);
      wr(2'd3, 32'hFF);
      wr(2'd2, {24'h0, VEC[k][22:15]});
      irq_req = VEC[k][14:7];
      repeat (2) @(negedge clk);
      check("R6 table level", 32'(irq_level), 32'(VEC[k][6:3]));
      check("R7 table src", 32'(irq_src), 32'(VEC[k][2:0]));
      rd(2'd0, r); check("R2 prio reserved", r, VEC[k][54:23] & 32'h00FF_FFFF);
      rd(2'd1, r); check("R3 raw", r, {24'h0, VEC[k][14:7] & 8'h3F});
    end

    done = 1'b1;
    finish_run();
  end
endmodule